// File: doc/BRIEF.md
# Watchdog Reset Timer

This block is a countdown watchdog with a small byte-wide register set. Software loads an 8-bit time value and enables the timer. The value then counts down once per second or once per minute. Each write of the time value restarts the count, and that write is the keepalive. If the count runs out, the block sets a sticky timeout flag and pulls an active-low reset output.

The reset output has two forms. It can be a level that holds until software acknowledges or stops the timer. It can also be a pulse whose width comes from a 2-bit code. A separate output-enable bit can keep the pin quiet, and the flag still records the expiry when it does.

All time bases come from the system clock through parameterised dividers: clocks per millisecond, milliseconds per second and seconds per minute. The timeout flag is cleared only by writing 1 to it or by the block's own power-on reset. It is therefore still visible after the system reset that the block itself caused.

Top module: `wdt_reset_timer`

## Requirements
- R1: Registers decode on `addr_i`. Address 0x30 bit 0 is the timer-domain enable. Address 0xF0 bit 7 is the output enable. Address 0xF6 is the 8-bit count. Address 0xF5 is the config register: bit 6 timeout flag, bit 5 timer enable, bit 4 pulse select (1 = pulse, 0 = level), bit 3 unit select (1 = minutes, 0 = seconds), bits 1:0 width code. Every other bit and address reads 0. After reset every register reads 0 and `wdt_rst_no` is 1.
- R2: The timer runs only while the domain enable and the timer enable are both 1. Otherwise the count does not change and no timeout occurs.
- R3: A running timer decrements the count once per unit tick. A seconds tick comes every CLK_PER_MS*MS_PER_SEC cycles. A minutes tick comes SEC_PER_MIN times less often. Address 0xF6 reads back the live count.
- R4: Writing 0xF6 loads the count and restarts the tick dividers. With period P and value N, expiry happens N*P cycles after the last such write.
- R5: Expiry occurs on a tick that finds the count at 1. The count becomes 0, and the timeout flag reads 1 from the next cycle on.
- R6: A count of 0 on a running timer expires on the first tick.
- R7: The timeout flag is sticky. Writing 1 to config bit 6 clears it. Writing 0 to that bit leaves it unchanged.
- R8: In level mode `wdt_rst_no` goes low on expiry and stays low. It is released one cycle after the flag is cleared or the timer stops.
- R9: In pulse mode `wdt_rst_no` is low for exactly PWk_MS*CLK_PER_MS cycles, where k is the width code in config bits 1:0.
- R10: With the output enable at 0, `wdt_rst_no` stays 1 on expiry, but the timeout flag is still set.
- R11: Clearing only the timer-enable bit keeps the other config bits and the count unchanged.
- R12: An expiry happens once per load. After it the count stays at 0 and no further timeout occurs until a reload or a restart of the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for both read and write |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| wdt_rst_no | output | 1 | Active-low reset output |

## Verification
The bench builds the block with CLK_PER_MS=2, MS_PER_SEC=5 and SEC_PER_MIN=4. This gives a seconds tick every 10 cycles and a minutes tick every 40 cycles, so both unit modes expire within a few hundred cycles. The pulse widths are set to 1, 2, 3 and 6 ms, which gives four distinct widths of 2, 4, 6 and 12 cycles. Each width code can therefore be measured exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W = 8;

  localparam logic [7:0] ADDR_DOM_EN = 8'h30;
  localparam logic [7:0] ADDR_OUT_EN = 8'hF0;
  localparam logic [7:0] ADDR_CFG    = 8'hF5;
  localparam logic [7:0] ADDR_CNT    = 8'hF6;

  localparam int unsigned CFG_STS_B   = 6;
  localparam int unsigned CFG_EN_B    = 5;
  localparam int unsigned CFG_PULSE_B = 4;
  localparam int unsigned CFG_MIN_B   = 3;
  localparam int unsigned OUT_EN_B    = 7;

  typedef struct packed {
    logic       sts;
    logic       en;
    logic       pulse;
    logic       min_unit;
    logic [1:0] pw;
  } cfg_t;
endpackage

// File: rtl/wdt_div_stage.sv
module wdt_div_stage #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = (cnt_q == W'(DIV - 1));
  assign tick_o = en_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= wrap ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned CLK_PER_MS  = 25000,
  parameter int unsigned MS_PER_SEC  = 1000,
  parameter int unsigned SEC_PER_MIN = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic min_sel_i,
  output logic tick_o
);
  localparam int unsigned NSTAGE = 3;
  localparam int unsigned DIVS [NSTAGE] = '{CLK_PER_MS, MS_PER_SEC, SEC_PER_MIN};

  logic [NSTAGE-1:0] tk;
  logic [NSTAGE-1:0] en;
  logic              clr;

  assign clr = restart_i | ~run_i;
  assign en  = {tk[NSTAGE-2:0], run_i};

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    wdt_div_stage #(.DIV(DIVS[g])) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (en[g]),
      .tick_o (tk[g])
    );
  end

  assign tick_o = min_sel_i ? tk[2] : tk[1];
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          run_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          fired_q;
  logic          at_end;

  assign at_end   = (cnt_q <= CW'(1));
  assign expire_o = run_i & tick_i & ~load_i & ~fired_q & at_end;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      fired_q <= 1'b0;
    end else if (!run_i) begin
      fired_q <= 1'b0;
    end else if (tick_i && !fired_q) begin
      if (at_end) begin
        cnt_q   <= '0;
        fired_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_rst_out.sv
module wdt_rst_out #(
  parameter int unsigned CLK_PER_MS = 25000,
  parameter int unsigned PW0_MS     = 1,
  parameter int unsigned PW1_MS     = 25,
  parameter int unsigned PW2_MS     = 125,
  parameter int unsigned PW3_MS     = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       fire_i,
  input  logic       pulse_i,
  input  logic [1:0] pw_i,
  input  logic       sts_i,
  input  logic       oe_i,
  output logic       rst_no
);
  localparam int unsigned PWC [4] = '{PW0_MS * CLK_PER_MS, PW1_MS * CLK_PER_MS,
                                      PW2_MS * CLK_PER_MS, PW3_MS * CLK_PER_MS};
  localparam int unsigned MAX01 = (PWC[0] > PWC[1]) ? PWC[0] : PWC[1];
  localparam int unsigned MAX23 = (PWC[2] > PWC[3]) ? PWC[2] : PWC[3];
  localparam int unsigned PWMAX = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned PW_W  = $clog2(PWMAX + 1);

  logic            act_q;
  logic            mode_q;
  logic [PW_W-1:0] pw_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      mode_q   <= 1'b0;
      pw_cnt_q <= '0;
    end else if (fire_i) begin
      act_q    <= 1'b1;
      mode_q   <= pulse_i;
      pw_cnt_q <= PW_W'(PWC[pw_i] - 1);
    end else if (!run_i) begin
      act_q    <= 1'b0;
    end else if (act_q) begin
      if (mode_q) begin
        if (pw_cnt_q == '0) act_q <= 1'b0;
        else                pw_cnt_q <= pw_cnt_q - PW_W'(1);
      end else if (!sts_i) begin
        act_q <= 1'b0;
      end
    end
  end

  assign rst_no = ~(oe_i & act_q);
endmodule

// File: rtl/wdt_reset_timer.sv
module wdt_reset_timer
  import wdt_pkg::*;
#(
  parameter int unsigned CLK_PER_MS  = 25000,
  parameter int unsigned MS_PER_SEC  = 1000,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned PW0_MS      = 1,
  parameter int unsigned PW1_MS      = 25,
  parameter int unsigned PW2_MS      = 125,
  parameter int unsigned PW3_MS      = 5000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             wdt_rst_no
);
  logic             dom_en_q;
  logic             oe_q;
  cfg_t             cfg_q;
  logic             sts_q;
  logic             run_w;
  logic             tick_w;
  logic             expire_w;
  logic [REG_W-1:0] cnt_w;
  logic             wr_dom, wr_oe, wr_cfg, wr_cnt;

  assign wr_dom = wr_en_i & (addr_i == ADDR_DOM_EN);
  assign wr_oe  = wr_en_i & (addr_i == ADDR_OUT_EN);
  assign wr_cfg = wr_en_i & (addr_i == ADDR_CFG);
  assign wr_cnt = wr_en_i & (addr_i == ADDR_CNT);

  assign run_w  = dom_en_q & cfg_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dom_en_q <= 1'b0;
      oe_q     <= 1'b0;
      cfg_q    <= '0;
    end else begin
      if (wr_dom) dom_en_q <= wdata_i[0];
      if (wr_oe)  oe_q     <= wdata_i[OUT_EN_B];
      if (wr_cfg) begin
        cfg_q.en       <= wdata_i[CFG_EN_B];
        cfg_q.pulse    <= wdata_i[CFG_PULSE_B];
        cfg_q.min_unit <= wdata_i[CFG_MIN_B];
        cfg_q.pw       <= wdata_i[1:0];
      end
    end
  end

  // status: expiry wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            sts_q <= 1'b0;
    else if (expire_w)                      sts_q <= 1'b1;
    else if (wr_cfg && wdata_i[CFG_STS_B])  sts_q <= 1'b0;
  end

  wdt_prescaler #(
    .CLK_PER_MS (CLK_PER_MS),
    .MS_PER_SEC (MS_PER_SEC),
    .SEC_PER_MIN(SEC_PER_MIN)
  ) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_w),
    .restart_i (wr_cnt),
    .min_sel_i (cfg_q.min_unit),
    .tick_o    (tick_w)
  );

  wdt_countdown #(.CW(REG_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_cnt),
    .load_val_i (wdata_i),
    .run_i      (run_w),
    .tick_i     (tick_w),
    .cnt_o      (cnt_w),
    .expire_o   (expire_w)
  );

  wdt_rst_out #(
    .CLK_PER_MS(CLK_PER_MS),
    .PW0_MS    (PW0_MS),
    .PW1_MS    (PW1_MS),
    .PW2_MS    (PW2_MS),
    .PW3_MS    (PW3_MS)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_w),
    .fire_i  (expire_w),
    .pulse_i (cfg_q.pulse),
    .pw_i    (cfg_q.pw),
    .sts_i   (sts_q),
    .oe_i    (oe_q),
    .rst_no  (wdt_rst_no)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_DOM_EN: rdata_o[0]        = dom_en_q;
      ADDR_OUT_EN: rdata_o[OUT_EN_B] = oe_q;
      ADDR_CFG: begin
        rdata_o[CFG_STS_B]   = sts_q;
        rdata_o[CFG_EN_B]    = cfg_q.en;
        rdata_o[CFG_PULSE_B] = cfg_q.pulse;
        rdata_o[CFG_MIN_B]   = cfg_q.min_unit;
        rdata_o[1:0]         = cfg_q.pw;
      end
      ADDR_CNT:    rdata_o = cnt_w;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_reset_timer_chk.sv
module wdt_reset_timer_chk
  import wdt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] addr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic             run,
  input logic             sts,
  input logic             expire,
  input logic [REG_W-1:0] cnt,
  input logic             rst_no
);
  a_r7_sts_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts && !(wr_en_i && addr_i == ADDR_CFG && wdata_i[CFG_STS_B]) |=> sts)
    else $error("a_r7_sts_sticky");

  a_r5_expire_sets_sts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> sts)
    else $error("a_r5_expire_sets_sts");

  a_r2_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && !(wr_en_i && addr_i == ADDR_CNT) |=> $stable(cnt))
    else $error("a_r2_cnt_frozen");

  a_r8_release_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> rst_no)
    else $error("a_r8_release_when_stopped");

  a_r4_reload_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == ADDR_CNT |=> cnt == $past(wdata_i))
    else $error("a_r4_reload_value");
endmodule

bind wdt_reset_timer wdt_reset_timer_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .run     (run_w),
  .sts     (sts_q),
  .expire  (expire_w),
  .cnt     (cnt_w),
  .rst_no  (wdt_rst_no)
);

// File: tb/tb_wdt_reset_timer.sv
module tb_wdt_reset_timer;
  localparam int unsigned P_SEC = 10;
  localparam int unsigned P_MIN = 40;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       wdt_rst_no;

  int total = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  wdt_reset_timer #(
    .CLK_PER_MS(2), .MS_PER_SEC(5), .SEC_PER_MIN(4),
    .PW0_MS(1), .PW1_MS(2), .PW2_MS(3), .PW3_MS(6)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .wdt_rst_no(wdt_rst_no)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  function automatic int sts_of(input logic [7:0] v);
    return int'(v[6]);
  endfunction

  task automatic arm(input logic [7:0] n, input logic [7:0] cfg, input logic oe);
    wr(8'h30, 8'h01);
    wr(8'hF0, oe ? 8'h80 : 8'h00);
    wr(8'hF6, n);
    wr(8'hF5, cfg);
  endtask

  task automatic stop_all();
    wr(8'hF5, 8'h40);
    wr(8'h30, 8'h00);
    wr(8'hF0, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h30, d); chk("R1 reset dom_en", d, 0);
    rd(8'hF0, d); chk("R1 reset out_en", d, 0);
    rd(8'hF5, d); chk("R1 reset cfg", d, 0);
    rd(8'hF6, d); chk("R1 reset cnt", d, 0);
    chk("R1 reset output high", wdt_rst_no, 1);
  endtask

  task automatic t_map_and_gate();
    logic [7:0] d;
    wr(8'hF6, 8'd2);
    wr(8'hF5, 8'hFF);
    rd(8'hF5, d); chk("R1 cfg readback mask", d, 8'h3B);
    wr(8'hF0, 8'hFF);
    rd(8'hF0, d); chk("R1 out_en readback mask", d, 8'h80);
    rd(8'h31, d); chk("R1 unmapped address", d, 0);
    cyc(5 * P_SEC);
    rd(8'hF6, d); chk("R2 count frozen without domain enable", d, 2);
    rd(8'hF5, d); chk("R2 no timeout without domain enable", sts_of(d), 0);
    wr(8'h30, 8'hFF);
    rd(8'h30, d); chk("R1 dom_en readback mask", d, 8'h01);
    wr(8'h30, 8'h00);
    wr(8'hF5, 8'h00);
    wr(8'hF0, 8'h00);
  endtask

  task automatic t_seconds_level();
    logic [7:0] d;
    arm(8'd3, 8'h20, 1'b1);
    cyc(P_SEC);
    rd(8'hF6, d); chk("R3 count after one seconds tick", d, 2);
    cyc(2 * P_SEC - 1);
    rd(8'hF5, d); chk("R5 no flag before expiry", sts_of(d), 0);
    chk("R8 output high before expiry", wdt_rst_no, 1);
    cyc(1);
    rd(8'hF5, d); chk("R5 flag at expiry", sts_of(d), 1);
    rd(8'hF6, d); chk("R5 count zero at expiry", d, 0);
    chk("R8 level output low", wdt_rst_no, 0);
    cyc(20);
    chk("R8 level held", wdt_rst_no, 0);
    wr(8'hF5, 8'h60);
    rd(8'hF5, d); chk("R7 flag cleared by write-1", sts_of(d), 0);
    cyc(1);
    chk("R8 level released after clear", wdt_rst_no, 1);
    cyc(3 * P_SEC);
    rd(8'hF5, d); chk("R12 no second expiry without reload", sts_of(d), 0);
    chk("R12 output stays high", wdt_rst_no, 1);
    stop_all();
  endtask

  task automatic t_keepalive();
    logic [7:0] d;
    arm(8'd2, 8'h20, 1'b1);
    cyc(15);
    wr(8'hF6, 8'd2);
    cyc(2 * P_SEC - 1);
    rd(8'hF5, d); chk("R4 reload postpones expiry", sts_of(d), 0);
    cyc(1);
    rd(8'hF5, d); chk("R4 expiry N*P after reload", sts_of(d), 1);
    stop_all();
  endtask

  task automatic t_minutes();
    logic [7:0] d;
    arm(8'd2, 8'h28, 1'b1);
    cyc(P_SEC);
    rd(8'hF6, d); chk("R3 no decrement on seconds tick in minute mode", d, 2);
    cyc(P_MIN - P_SEC);
    rd(8'hF6, d); chk("R3 count after one minutes tick", d, 1);
    cyc(P_MIN - 1);
    rd(8'hF5, d); chk("R3 no minute expiry early", sts_of(d), 0);
    cyc(1);
    rd(8'hF5, d); chk("R3 minute expiry", sts_of(d), 1);
    stop_all();
  endtask

  task automatic t_zero_and_disable();
    logic [7:0] d;
    arm(8'd0, 8'h20, 1'b1);
    cyc(P_SEC - 1);
    rd(8'hF5, d); chk("R6 no expiry before first tick", sts_of(d), 0);
    cyc(1);
    rd(8'hF5, d); chk("R6 zero count expires on first tick", sts_of(d), 1);
    chk("R6 output low", wdt_rst_no, 0);
    wr(8'hF5, 8'h00);
    cyc(1);
    chk("R8 level released on stop", wdt_rst_no, 1);
    rd(8'hF5, d); chk("R7 writing 0 keeps flag", sts_of(d), 1);
    stop_all();
  endtask

  task automatic t_pulse(input int code, input int width);
    logic [7:0] d;
    int n;
    arm(8'd1, 8'h30 | 8'(code), 1'b1);
    cyc(P_SEC - 1);
    chk($sformatf("R9 high before pulse code %0d", code), wdt_rst_no, 1);
    cyc(1);
    n = 0;
    while (wdt_rst_no == 1'b0 && n < 100) begin
      n++;
      cyc(1);
    end
    chk($sformatf("R9 pulse width code %0d", code), n, width);
    rd(8'hF5, d); chk("R7 flag survives pulse", sts_of(d), 1);
    stop_all();
  endtask

  task automatic t_oe_off();
    logic [7:0] d;
    arm(8'd1, 8'h20, 1'b0);
    cyc(P_SEC);
    rd(8'hF5, d); chk("R10 flag set with output disabled", sts_of(d), 1);
    chk("R10 output stays high", wdt_rst_no, 1);
    cyc(5);
    chk("R10 output still high", wdt_rst_no, 1);
    stop_all();
  endtask

  task automatic t_stop_keeps();
    logic [7:0] d;
    arm(8'd3, 8'h2A, 1'b1);
    cyc(5);
    wr(8'hF5, 8'h0A);
    rd(8'hF5, d); chk("R11 other config bits kept", d, 8'h0A);
    cyc(3 * P_MIN);
    rd(8'hF6, d); chk("R11 count kept while stopped", d, 3);
    rd(8'hF5, d); chk("R2 no expiry while stopped", sts_of(d), 0);
    stop_all();
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    total++; fails++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_map_and_gate();
    t_seconds_level();
    t_keepalive();
    t_minutes();
    t_zero_and_disable();
    t_pulse(0, 2);
    t_pulse(1, 4);
    t_pulse(2, 6);
    t_pulse(3, 12);
    t_oe_off();
    t_stop_keeps();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule